// File: doc/BRIEF.md
# Cascadable Two-Level Interrupt Controller

The block gathers up to 32 level-sensitive interrupt sources into two processor request lines: a normal request (`irq`) and a fast request (`fiq`). A single raw level vector is shared by both lines. Each line has its own enable mask. A source drives a line when the source is high and its bit is set in that line's mask. Software changes each mask through a pair of registers. One register sets the bits written as 1, and the other clears the bits written as 1, so a read-modify-write is never needed.

Source 0 has a software component. A register sets a software bit, another register clears it, and that bit is ORed with external input 0. The software bit lets a CPU post an interrupt to itself.

Instances can be chained into a tree. The `irq` output of a secondary instance is wired to one source input of a primary instance, so the secondary shows up as a single source. Only the secondary's normal-request enables take part in that line. Its fast-request enables never reach the primary.

Top module: `cascade_intc`

## Requirements
- R1: While reset is asserted and right after it is released, `irq` and `fiq` are 0, both enable masks read 0 and the software bit reads 0. This holds whatever the source inputs are.
- R2: A write to word offset 2 ORs `wrData` into the normal enable mask. A read of offset 2 returns that mask. Bits at or above `NUM_SRC` are dropped and read back as 0.
- R3: A write to word offset 3 clears each normal enable bit whose `wrData` bit is 1. All other bits are kept, and the fast enable mask is untouched.
- R4: Word offset 10 sets fast enable bits, word offset 11 clears them, and a read of offset 10 returns the fast enable mask. These writes never change the normal enable mask.
- R5: Reads of offsets 1 and 9 both return the raw level. Bit i of the raw level (i ≥ 1) equals `srcIn[i]` in the same cycle. Bit 0 is `srcIn[0]` OR the software bit.
- R6: A read of offset 0 returns raw level AND normal mask. A read of offset 8 returns raw level AND fast mask.
- R7: A write to offset 4 with `wrData[0]`=1 sets the software bit. A write to offset 5 with `wrData[0]`=1 clears it. Writes to either offset with `wrData[0]`=0 have no effect. A read of offset 4 returns raw bit 0 in bit 0 and zeros above it.
- R8: On each rising clock edge, `irq` takes the value of (raw level AND normal mask) ≠ 0 as it stood just before that edge. A source change therefore appears after the next edge. A mask write appears one edge after the edge that captures the write.
- R9: `fiq` follows the same rule as `irq`, using the fast mask.
- R10: When the `irq` of a secondary instance drives a source input of a primary, that source is raised exactly when the secondary has a source that is both high and normal-enabled. Fast enables in the secondary have no effect on it.
- R11: `rdData` is 0 when `rdEn` is low. It is also 0 when reading the write-only offsets 3, 5 and 11 or any undefined offset (6, 7, 12–15).
- R12: Writes to the status offsets 0, 1, 8 and 9 and to undefined offsets change neither mask nor the software bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| rdEn | input | 1 | Register read strobe; `rdData` is valid in the same cycle |
| addr | input | ADDR_W | Word offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational from state and sources |
| srcIn | input | NUM_SRC | Level-sensitive interrupt sources |
| irq | output | 1 | Registered normal interrupt request |
| fiq | output | 1 | Registered fast interrupt request |

## Verification
The bench builds two instances with `NUM_SRC` = 8. This makes the source space small enough to sweep all 256 input patterns against fixed, distinct normal and fast masks. For each pattern it checks the raw read, both masked reads and both outputs, both before and after the sampling edge. The second instance is chained into source 3 of the first. This shows that only the secondary's normal enables propagate up the tree. Upper write-data bits beyond the eight sources exercise the truncation of masks.

// File: rtl/cascade_intc_pkg.sv
package cascade_intc_pkg;

  localparam int DATA_W = 32;

  // word offsets; software drivers depend on these positions
  localparam int OFS_IRQ_STAT   = 0;
  localparam int OFS_RAW        = 1;
  localparam int OFS_IRQ_EN_SET = 2;
  localparam int OFS_IRQ_EN_CLR = 3;
  localparam int OFS_SW_SET     = 4;
  localparam int OFS_SW_CLR     = 5;
  localparam int OFS_FIQ_STAT   = 8;
  localparam int OFS_FIQ_RAW    = 9;
  localparam int OFS_FIQ_EN_SET = 10;
  localparam int OFS_FIQ_EN_CLR = 11;

  // update strobes from decode to the state registers
  typedef struct packed {
    logic irqSet;
    logic irqClr;
    logic fiqSet;
    logic fiqClr;
    logic swSet;
    logic swClr;
  } regStrobes_t;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_IRQ_STAT,
    SEL_RAW,
    SEL_IRQ_EN,
    SEL_SW,
    SEL_FIQ_STAT,
    SEL_FIQ_EN
  } readSel_e;

endpackage

// File: rtl/cascade_intc_ctrl.sv
module cascade_intc_ctrl
  import cascade_intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               swWrBit,
  input  logic [NUM_SRC-1:0] irqEn,
  input  logic [NUM_SRC-1:0] fiqEn,
  input  logic [NUM_SRC-1:0] rawLevel,
  output regStrobes_t        stb,
  output logic [DATA_W-1:0]  rdData
);

  localparam logic [ADDR_W-1:0] A_IRQ_STAT   = ADDR_W'(OFS_IRQ_STAT);
  localparam logic [ADDR_W-1:0] A_RAW        = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_IRQ_EN_SET = ADDR_W'(OFS_IRQ_EN_SET);
  localparam logic [ADDR_W-1:0] A_IRQ_EN_CLR = ADDR_W'(OFS_IRQ_EN_CLR);
  localparam logic [ADDR_W-1:0] A_SW_SET     = ADDR_W'(OFS_SW_SET);
  localparam logic [ADDR_W-1:0] A_SW_CLR     = ADDR_W'(OFS_SW_CLR);
  localparam logic [ADDR_W-1:0] A_FIQ_STAT   = ADDR_W'(OFS_FIQ_STAT);
  localparam logic [ADDR_W-1:0] A_FIQ_RAW    = ADDR_W'(OFS_FIQ_RAW);
  localparam logic [ADDR_W-1:0] A_FIQ_EN_SET = ADDR_W'(OFS_FIQ_EN_SET);
  localparam logic [ADDR_W-1:0] A_FIQ_EN_CLR = ADDR_W'(OFS_FIQ_EN_CLR);

  readSel_e           rdSel;
  logic [NUM_SRC-1:0] rdVal;

  // write decode: status and undefined offsets raise no strobe
  always_comb begin
    stb = '0;
    if (wrEn) begin
      case (addr)
        A_IRQ_EN_SET: stb.irqSet = 1'b1;
        A_IRQ_EN_CLR: stb.irqClr = 1'b1;
        A_FIQ_EN_SET: stb.fiqSet = 1'b1;
        A_FIQ_EN_CLR: stb.fiqClr = 1'b1;
        A_SW_SET:     stb.swSet  = swWrBit;
        A_SW_CLR:     stb.swClr  = swWrBit;
        default:      stb = '0;
      endcase
    end
  end

  // read decode: write-only and undefined offsets select zero
  always_comb begin
    rdSel = SEL_ZERO;
    if (rdEn) begin
      case (addr)
        A_IRQ_STAT:   rdSel = SEL_IRQ_STAT;
        A_RAW:        rdSel = SEL_RAW;
        A_FIQ_RAW:    rdSel = SEL_RAW;
        A_IRQ_EN_SET: rdSel = SEL_IRQ_EN;
        A_SW_SET:     rdSel = SEL_SW;
        A_FIQ_STAT:   rdSel = SEL_FIQ_STAT;
        A_FIQ_EN_SET: rdSel = SEL_FIQ_EN;
        default:      rdSel = SEL_ZERO;
      endcase
    end
  end

  always_comb begin
    case (rdSel)
      SEL_IRQ_STAT: rdVal = rawLevel & irqEn;
      SEL_RAW:      rdVal = rawLevel;
      SEL_IRQ_EN:   rdVal = irqEn;
      SEL_SW:       rdVal = {{(NUM_SRC-1){1'b0}}, rawLevel[0]};
      SEL_FIQ_STAT: rdVal = rawLevel & fiqEn;
      SEL_FIQ_EN:   rdVal = fiqEn;
      default:      rdVal = '0;
    endcase
  end

  assign rdData = DATA_W'(rdVal);

endmodule

// File: rtl/cascade_intc_datapath.sv
module cascade_intc_datapath
  import cascade_intc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobes_t        stb,
  input  logic [NUM_SRC-1:0] wrMask,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [NUM_SRC-1:0] irqEn,
  output logic [NUM_SRC-1:0] fiqEn,
  output logic [NUM_SRC-1:0] rawLevel,
  output logic               irq,
  output logic               fiq
);

  logic [NUM_SRC-1:0] irqEnQ;
  logic [NUM_SRC-1:0] fiqEnQ;
  logic               swQ;
  logic               irqQ;
  logic               fiqQ;

  // raw level: bit 0 merges the software bit, the rest pass straight through
  for (genvar i = 0; i < NUM_SRC; i++) begin : gRaw
    if (i == 0) begin : gSoft
      assign rawLevel[i] = srcIn[i] | swQ;
    end else begin : gExt
      assign rawLevel[i] = srcIn[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEnQ <= '0;
      fiqEnQ <= '0;
      swQ    <= 1'b0;
      irqQ   <= 1'b0;
      fiqQ   <= 1'b0;
    end else begin
      irqEnQ <= (irqEnQ | (stb.irqSet ? wrMask : '0)) & ~(stb.irqClr ? wrMask : '0);
      fiqEnQ <= (fiqEnQ | (stb.fiqSet ? wrMask : '0)) & ~(stb.fiqClr ? wrMask : '0);
      if (stb.swSet) begin
        swQ <= 1'b1;
      end else if (stb.swClr) begin
        swQ <= 1'b0;
      end
      irqQ <= |(rawLevel & irqEnQ);
      fiqQ <= |(rawLevel & fiqEnQ);
    end
  end

  assign irqEn = irqEnQ;
  assign fiqEn = fiqEnQ;
  assign irq   = irqQ;
  assign fiq   = fiqQ;

endmodule

// File: rtl/cascade_intc.sv
module cascade_intc
  import cascade_intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irq,
  output logic               fiq
);

  regStrobes_t        stb;
  logic [NUM_SRC-1:0] irqEn;
  logic [NUM_SRC-1:0] fiqEn;
  logic [NUM_SRC-1:0] rawLevel;

  cascade_intc_ctrl #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W)
  ) ctrl_i (
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .addr     (addr),
    .swWrBit  (wrData[0]),
    .irqEn    (irqEn),
    .fiqEn    (fiqEn),
    .rawLevel (rawLevel),
    .stb      (stb),
    .rdData   (rdData)
  );

  cascade_intc_datapath #(
    .NUM_SRC (NUM_SRC)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrMask   (wrData[NUM_SRC-1:0]),
    .srcIn    (srcIn),
    .irqEn    (irqEn),
    .fiqEn    (fiqEn),
    .rawLevel (rawLevel),
    .irq      (irq),
    .fiq      (fiq)
  );

endmodule

// File: rtl/cascade_intc_chk.sv
module cascade_intc_chk #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic               rdEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [31:0]        wrData,
  input logic [31:0]        rdData,
  input logic [NUM_SRC-1:0] srcIn,
  input logic               irq,
  input logic               fiq,
  input logic [NUM_SRC-1:0] irqEn,
  input logic [NUM_SRC-1:0] fiqEn,
  input logic [NUM_SRC-1:0] rawLevel
);

  // R2
  irq_en_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(2)) |=>
      ((irqEn & $past(wrData[NUM_SRC-1:0])) == $past(wrData[NUM_SRC-1:0])));

  // R3
  irq_en_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(3)) |=> ((irqEn & $past(wrData[NUM_SRC-1:0])) == '0));

  // R4
  fiq_en_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(10)) |=>
      ((fiqEn & $past(wrData[NUM_SRC-1:0])) == $past(wrData[NUM_SRC-1:0])));

  // R12
  irq_en_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(irqEn) && $stable(fiqEn));

  // R7
  sw_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(4) && wrData[0]) |=> rawLevel[0]);

  // R7
  sw_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(5) && wrData[0]) |=> (rawLevel[0] == srcIn[0]));

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irq == $past(|(rawLevel & irqEn))));

  // R9
  fiq_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (fiq == $past(|(rawLevel & fiqEn))));

  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> (rdData == '0));

endmodule

bind cascade_intc cascade_intc_chk #(
  .NUM_SRC (NUM_SRC),
  .ADDR_W  (ADDR_W)
) chk_i (.*);

// File: tb/cascade_intc_tb_top.sv
`timescale 1ns/1ps
module cascade_intc_tb_top;

  localparam int NS   = 8;
  localparam int AW   = 4;
  localparam int CASC = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN;
  logic        pWr, pRd, sWr, sRd;
  logic [AW-1:0] pAddr, sAddr;
  logic [31:0] pWd, sWd;
  wire  [31:0] pRdData, sRdData;
  wire         pIrq, pFiq, sIrq, sFiq;
  logic [NS-1:0] srcDrv, secSrc;
  wire  [NS-1:0] pSrc = srcDrv | (NS'(sIrq) << CASC);

  int errors = 0;
  int checks = 0;

  cascade_intc #(.NUM_SRC(NS), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(pWr), .rdEn(pRd), .addr(pAddr),
    .wrData(pWd), .rdData(pRdData), .srcIn(pSrc), .irq(pIrq), .fiq(pFiq));

  cascade_intc #(.NUM_SRC(NS), .ADDR_W(AW)) sec_i (
    .clk(clk), .rstN(rstN), .wrEn(sWr), .rdEn(sRd), .addr(sAddr),
    .wrData(sWd), .rdData(sRdData), .srcIn(secSrc), .irq(sIrq), .fiq(sFiq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic busWr(input bit sec, input int a, input logic [31:0] d);
    @(negedge clk);
    if (sec) begin sWr = 1'b1; sAddr = a[AW-1:0]; sWd = d; end
    else     begin pWr = 1'b1; pAddr = a[AW-1:0]; pWd = d; end
    @(negedge clk);
    sWr = 1'b0;
    pWr = 1'b0;
  endtask

  task automatic busRd(input bit sec, input int a, output logic [31:0] d);
    if (sec) begin sRd = 1'b1; sAddr = a[AW-1:0]; end
    else     begin pRd = 1'b1; pAddr = a[AW-1:0]; end
    #1;
    d = sec ? sRdData : pRdData;
    sRd = 1'b0;
    pRd = 1'b0;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] v;
    logic [NS-1:0] mI, mF, prev;
    pWr = 0; pRd = 0; sWr = 0; sRd = 0;
    pAddr = '0; sAddr = '0; pWd = '0; sWd = '0;
    srcDrv = '1; secSrc = '0;
    rstN = 1'b0;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {31'b0, pIrq}, 32'h0);
    chk("R1 fiq in reset", {31'b0, pFiq}, 32'h0);
    rstN = 1'b1;
    busRd(0, 2, v); chk("R1 irq mask", v, 32'h0);
    busRd(0, 10, v); chk("R1 fiq mask", v, 32'h0);
    srcDrv = '0;
    busRd(0, 4, v); chk("R1 sw bit", v, 32'h0);
    srcDrv = '1;
    repeat (2) @(negedge clk);
    chk("R1 irq low after reset", {31'b0, pIrq}, 32'h0);
    chk("R1 fiq low after reset", {31'b0, pFiq}, 32'h0);
    srcDrv = '0;

    // R2 R3 R4 mask set/clear
    busWr(0, 2, 32'h0F); busWr(0, 2, 32'hF0);
    busRd(0, 2, v); chk("R2 set accumulates", v, 32'hFF);
    busWr(0, 3, 32'h3C);
    busRd(0, 2, v); chk("R3 clear selected bits", v, 32'hC3);
    busWr(0, 2, 32'hFFFF_FF00);
    busRd(0, 2, v); chk("R2 upper bits dropped", v, 32'hC3);
    busWr(0, 10, 32'h81); busWr(0, 10, 32'h18);
    busRd(0, 10, v); chk("R4 fiq set", v, 32'h99);
    busWr(0, 11, 32'h09);
    busRd(0, 10, v); chk("R4 fiq clear", v, 32'h90);
    busRd(0, 2, v); chk("R4 irq mask untouched", v, 32'hC3);
    busWr(0, 3, 32'hFF); busWr(0, 11, 32'hFF);
    busRd(0, 10, v); chk("R3 full clear", v, 32'h0);

    // R5 R6 R8 R9 exhaustive source sweep
    mI = 8'hA5; mF = 8'h3C;
    busWr(0, 2, {24'b0, mI}); busWr(0, 10, {24'b0, mF});
    @(negedge clk);
    prev = '0;
    for (int s = 0; s < 256; s++) begin
      @(negedge clk);
      srcDrv = s[NS-1:0];
      chk("R8 irq before edge", {31'b0, pIrq}, {31'b0, |(prev & mI)});
      chk("R9 fiq before edge", {31'b0, pFiq}, {31'b0, |(prev & mF)});
      busRd(0, 1, v); chk("R5 raw", v, 32'(s));
      busRd(0, 9, v); chk("R5 raw alias", v, 32'(s));
      busRd(0, 0, v); chk("R6 irq status", v, 32'(s[NS-1:0] & mI));
      busRd(0, 8, v); chk("R6 fiq status", v, 32'(s[NS-1:0] & mF));
      @(negedge clk);
      chk("R8 irq after edge", {31'b0, pIrq}, {31'b0, |(s[NS-1:0] & mI)});
      chk("R9 fiq after edge", {31'b0, pFiq}, {31'b0, |(s[NS-1:0] & mF)});
      prev = s[NS-1:0];
    end

    // R7 software source
    srcDrv = '0;
    busWr(0, 4, 32'hFFFF_FFFE);
    busRd(0, 4, v); chk("R7 set without bit0 ignored", v, 32'h0);
    busWr(0, 4, 32'h1);
    busRd(0, 4, v); chk("R7 sw set", v, 32'h1);
    busRd(0, 1, v); chk("R5 sw in raw", v, 32'h1);
    @(negedge clk);
    chk("R8 irq from sw", {31'b0, pIrq}, 32'h1);
    chk("R9 fiq masked sw", {31'b0, pFiq}, 32'h0);
    busWr(0, 5, 32'hFFFF_FFFE);
    busRd(0, 4, v); chk("R7 clear without bit0 ignored", v, 32'h1);

    // R12 writes to status and undefined offsets
    foreach (v[i]) if (i < 1) ;
    busWr(0, 0, '1); busWr(0, 1, '1); busWr(0, 8, '1); busWr(0, 9, '1);
    busWr(0, 6, '1); busWr(0, 7, '1); busWr(0, 12, '1); busWr(0, 15, '1);
    busRd(0, 2, v); chk("R12 irq mask kept", v, 32'hA5);
    busRd(0, 10, v); chk("R12 fiq mask kept", v, 32'h3C);
    busRd(0, 4, v); chk("R12 sw kept", v, 32'h1);

    // R11 reads of write-only, undefined, and idle bus
    busRd(0, 3, v); chk("R11 offset 3", v, 32'h0);
    busRd(0, 5, v); chk("R11 offset 5", v, 32'h0);
    busRd(0, 11, v); chk("R11 offset 11", v, 32'h0);
    busRd(0, 6, v); chk("R11 offset 6", v, 32'h0);
    busRd(0, 7, v); chk("R11 offset 7", v, 32'h0);
    for (int a = 12; a < 16; a++) begin
      busRd(0, a, v); chk("R11 upper offsets", v, 32'h0);
    end
    pAddr = 4'd2; pRd = 1'b0; #1;
    chk("R11 rdEn low", pRdData, 32'h0);

    // R7 clear with source 0 high, then low
    srcDrv = 8'h01;
    busWr(0, 5, 32'h1);
    busRd(0, 4, v); chk("R7 clear keeps external src0", v, 32'h1);
    srcDrv = '0; #1;
    busRd(0, 4, v); chk("R7 sw cleared", v, 32'h0);

    // R8 write latency
    srcDrv = 8'h40;
    @(negedge clk); @(negedge clk);
    chk("R8 unmasked source idle", {31'b0, pIrq}, 32'h0);
    busWr(0, 2, 32'h40);
    chk("R8 mask write not yet visible", {31'b0, pIrq}, 32'h0);
    @(negedge clk);
    chk("R8 mask write visible", {31'b0, pIrq}, 32'h1);
    busWr(0, 3, 32'h40);
    chk("R8 clear not yet visible", {31'b0, pIrq}, 32'h1);
    @(negedge clk);
    chk("R8 clear visible", {31'b0, pIrq}, 32'h0);
    srcDrv = '0;

    // R10 cascade through source 3
    busWr(0, 3, 32'hFF); busWr(0, 11, 32'hFF);
    busWr(0, 2, 32'(1 << CASC));
    busWr(1, 10, 32'h01);
    secSrc = 8'h01;
    @(negedge clk); @(negedge clk);
    chk("R10 secondary fiq", {31'b0, sFiq}, 32'h1);
    chk("R10 fiq enable kept off cascade", {31'b0, sIrq}, 32'h0);
    busRd(0, 1, v); chk("R10 primary raw quiet", v, 32'h0);
    chk("R10 primary irq quiet", {31'b0, pIrq}, 32'h0);
    busWr(1, 2, 32'h01);
    @(negedge clk);
    chk("R10 secondary irq", {31'b0, sIrq}, 32'h1);
    busRd(0, 1, v); chk("R10 primary raw bit3", v, 32'(1 << CASC));
    @(negedge clk);
    chk("R10 primary irq", {31'b0, pIrq}, 32'h1);
    secSrc = '0;
    @(negedge clk);
    chk("R10 secondary drop", {31'b0, sIrq}, 32'h0);
    @(negedge clk);
    chk("R10 primary drop", {31'b0, pIrq}, 32'h0);

    report();
  end

endmodule